// File: doc/BRIEF.md
# Encoder Position Counter with Capture and Preset

This block keeps a signed-agnostic position count from step pulses produced by an upstream quadrature decoder. Each cycle the decoder may assert a count enable together with a direction. The counter advances by one in the given direction. It wraps at its width and records whether it wrapped upward or downward. A controller drives an 8-bit control word that arms capture sources and requests preset loads. The block answers with an 8-bit status word.

One latch register is shared by two capture sources. The first is a reference (index) input. The second is an external latch input, which can be armed for its rising edge, its falling edge, or both. Each capture fires once per arming and raises a valid flag. While that flag is high, its source cannot write the latch again. A reference capture outranks an external capture that lands in the same cycle. The reference valid flag is released only once its enable is off and the reference input has returned low. Both asynchronous inputs pass through two-stage synchronizers before any edge is taken from them.

Top module: `enc_capture_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `count`, `latch_val` and all of `status` become zero.
- R2: With `cnt_en` high, `count` increments by one per cycle when `cnt_dir` is 1 and decrements by one when `cnt_dir` is 0. With `cnt_en` low, it holds.
- R3: A count step up from all-ones to zero sets `status[4]` (overflow). The flag stays set until the next preset load.
- R4: A count step down from zero to all-ones sets `status[3]` (underflow). The flag stays set until the next preset load.
- R5: A 0-to-1 transition of `ctrl[2]` loads `preset_val` into `count` at the next clock edge and clears both wrap flags. Keeping `ctrl[2]` high causes no further load.
- R6: `status[2]` (preset acknowledge) goes high one cycle after the load while `ctrl[2]` stays high. It goes low on the edge after `ctrl[2]` is low.
- R7: With `ctrl[1]` set, the first rising edge of the synchronized `ext_in` copies `count` into `latch_val` and sets `status[1]`. This happens three clock edges after `ext_in` changes.
- R8: With `ctrl[3]` set, the first falling edge of the synchronized `ext_in` copies `count` into `latch_val` and sets `status[1]`.
- R9: While `status[1]` is high, further `ext_in` edges leave `latch_val` unchanged.
- R10: With `ctrl[0]` set and `status[0]` low, a rising edge of the synchronized `ref_in` copies `count` into `latch_val` and sets `status[0]`.
- R11: When a reference capture and an external capture fall in the same cycle, the latch takes the reference capture and `status[1]` stays low.
- R12: `status[0]` is cleared only when `ctrl[0]` is low and the synchronized `ref_in` is low. While `ref_in` stays high, the flag holds.
- R13: `status[1]` clears on the edge after both `ctrl[1]` and `ctrl[3]` are low. Setting either bit again re-arms the external capture.
- R14: `status[5]` shows the synchronized level of `ext_in` two edges after it changes. `status[7:6]` read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en | input | 1 | Count step request from the decoder |
| cnt_dir | input | 1 | Step direction, 1 = up, 0 = down |
| ref_in | input | 1 | Reference (index) pulse, asynchronous |
| ext_in | input | 1 | External latch input, asynchronous |
| preset_val | input | 32 | Value loaded on a preset request |
| ctrl | input | 8 | Control word: bit0 reference arm, bit1 ext rise arm, bit2 preset request, bit3 ext fall arm, bits 7:4 ignored |
| count | output | 32 | Live counter value |
| latch_val | output | 32 | Shared capture register |
| status | output | 8 | Status word: bit0 reference valid, bit1 external valid, bit2 preset ack, bit3 underflow, bit4 overflow, bit5 ext level, bits 7:6 zero |

## Verification
A reference capture and an external capture can both become ready in the same clock cycle. The priority rule decides which one writes the shared latch. To provoke this, both captures are armed and `ref_in` and `ext_in` are driven high on the same falling clock edge. Their synchronized rising edges then arrive together. The expected result is that `latch_val` holds the count at that moment, `status[0]` is set and `status[1]` stays clear. Because the external edge has already passed, no external capture follows later.

// File: rtl/enc_cap_pkg.sv
// Package: shared bit positions of the control and status words.
// Assumes an 8-bit control word and an 8-bit status word.
package enc_cap_pkg;
    localparam int CTRL_W       = 8;
    localparam int STAT_W       = 8;
    // control word bit positions
    localparam int CB_REF_ARM   = 0;
    localparam int CB_EXT_RISE  = 1;
    localparam int CB_PRESET    = 2;
    localparam int CB_EXT_FALL  = 3;
    // status word bit positions
    localparam int SB_REF_VLD   = 0;
    localparam int SB_EXT_VLD   = 1;
    localparam int SB_PRE_ACK   = 2;
    localparam int SB_UNDER     = 3;
    localparam int SB_OVER      = 4;
    localparam int SB_EXT_LVL   = 5;

    typedef struct packed {
        logic ref_arm;
        logic ext_rise_arm;
        logic preset_req;
        logic ext_fall_arm;
    } ctrl_fields_t;
endpackage

// File: rtl/ecc_sync_edge.sv
// ecc_sync_edge: multi-stage synchronizer for one asynchronous input, with
// rise and fall detection on the synchronized level.
// Assumes STAGES >= 2. Edge outputs are one-cycle pulses.
module ecc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // shift the input through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    // remember the last synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~prev;
    assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/ecc_preset_ctl.sv
// ecc_preset_ctl: turns the preset request level into a one-cycle load
// pulse on its rising edge, and produces the acknowledge flag.
// Assumes the request is already synchronous to clk.
module ecc_preset_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic load,
    output logic ack
);
    logic req_q;

    // remember the previous request level
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req;
    end

    // acknowledge goes high the cycle after a load while the request stays high
    always_ff @(posedge clk) begin
        if (!rst_n) ack <= 1'b0;
        else        ack <= req & req_q;
    end

    assign load = req & ~req_q;
endmodule

// File: rtl/ecc_pos_counter.sv
// ecc_pos_counter: wrapping up/down counter with preset load and sticky
// wrap flags. A load takes priority over a step in the same cycle and
// clears both wrap flags.
// Assumes W >= 2.
module ecc_pos_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         up,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         ovf,
    output logic         unf
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
    localparam logic [W-1:0] CNT_MIN = '0;

    logic wrap_up;
    logic wrap_dn;

    // detect a step that crosses the counter boundary
    always_comb begin
        wrap_up = step & up  & (count == CNT_MAX);
        wrap_dn = step & ~up & (count == CNT_MIN);
    end

    // counter register: load first, then step
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (load)  count <= load_val;
        else if (step)  count <= up ? count + 1'b1 : count - 1'b1;
    end

    // sticky wrap flags, cleared by a preset load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
            unf <= 1'b0;
        end else if (load) begin
            ovf <= 1'b0;
            unf <= 1'b0;
        end else begin
            if (wrap_up) ovf <= 1'b1;
            if (wrap_dn) unf <= 1'b1;
        end
    end
endmodule

// File: rtl/ecc_capture.sv
// ecc_capture: shared latch register fed by a reference capture and an
// external-edge capture. Each capture is one-shot and guarded by its own
// valid flag. The reference capture wins a same-cycle contest.
// Assumes all edge and level inputs are synchronous to clk.
module ecc_capture #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ref_arm,
    input  logic         rise_arm,
    input  logic         fall_arm,
    input  logic         ref_lvl,
    input  logic         ref_rise,
    input  logic         ext_rise,
    input  logic         ext_fall,
    input  logic [W-1:0] count,
    output logic [W-1:0] latch_q,
    output logic         ref_vld,
    output logic         ext_vld,
    output logic         ref_take,
    output logic         ext_take
);
    logic ext_hit;

    // decide which capture writes the latch this cycle
    always_comb begin
        ref_take = ref_arm & ref_rise & ~ref_vld;
        ext_hit  = (rise_arm & ext_rise) | (fall_arm & ext_fall);
        ext_take = ext_hit & ~ext_vld & ~ref_take;
    end

    // shared latch register
    always_ff @(posedge clk) begin
        if (!rst_n)                    latch_q <= '0;
        else if (ref_take || ext_take) latch_q <= count;
    end

    // reference valid: set on capture, released once disarmed with input low
    always_ff @(posedge clk) begin
        if (!rst_n)                   ref_vld <= 1'b0;
        else if (ref_take)            ref_vld <= 1'b1;
        else if (!ref_arm && !ref_lvl) ref_vld <= 1'b0;
    end

    // external valid: set on capture, released once both arms are off
    always_ff @(posedge clk) begin
        if (!rst_n)                     ext_vld <= 1'b0;
        else if (ext_take)              ext_vld <= 1'b1;
        else if (!rise_arm && !fall_arm) ext_vld <= 1'b0;
    end
endmodule

// File: rtl/enc_capture_ctrl.sv
// enc_capture_ctrl: position counter with reference/external capture and
// preset loading, driven by a control word and reporting a status word.
// Assumes ctrl, preset_val, cnt_en and cnt_dir are synchronous to clk;
// ref_in and ext_in may be asynchronous.
module enc_capture_ctrl
    import enc_cap_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              cnt_dir,
    input  logic              ref_in,
    input  logic              ext_in,
    input  logic [CNT_W-1:0]  preset_val,
    input  logic [CTRL_W-1:0] ctrl,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  latch_val,
    output logic [STAT_W-1:0] status
);
    ctrl_fields_t cf;
    logic unused_ctrl_bits;
    logic ref_lvl, ref_rise, ref_fall_nc;
    logic ext_lvl, ext_rise, ext_fall;
    logic preset_load, preset_ack;
    logic ovf, unf;
    logic ref_vld, ext_vld, ref_take, ext_take;

    // unpack the control word fields the block uses
    always_comb begin
        cf.ref_arm      = ctrl[CB_REF_ARM];
        cf.ext_rise_arm = ctrl[CB_EXT_RISE];
        cf.preset_req   = ctrl[CB_PRESET];
        cf.ext_fall_arm = ctrl[CB_EXT_FALL];
    end
    assign unused_ctrl_bits = ^{ctrl[CTRL_W-1:4], ref_fall_nc};

    ecc_sync_edge #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk(clk), .rst_n(rst_n), .d_async(ref_in),
        .lvl(ref_lvl), .rise(ref_rise), .fall(ref_fall_nc)
    );

    ecc_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .d_async(ext_in),
        .lvl(ext_lvl), .rise(ext_rise), .fall(ext_fall)
    );

    ecc_preset_ctl u_preset (
        .clk(clk), .rst_n(rst_n), .req(cf.preset_req),
        .load(preset_load), .ack(preset_ack)
    );

    ecc_pos_counter #(.W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .step(cnt_en), .up(cnt_dir),
        .load(preset_load), .load_val(preset_val),
        .count(count), .ovf(ovf), .unf(unf)
    );

    ecc_capture #(.W(CNT_W)) u_capture (
        .clk(clk), .rst_n(rst_n),
        .ref_arm(cf.ref_arm), .rise_arm(cf.ext_rise_arm), .fall_arm(cf.ext_fall_arm),
        .ref_lvl(ref_lvl), .ref_rise(ref_rise),
        .ext_rise(ext_rise), .ext_fall(ext_fall),
        .count(count), .latch_q(latch_val),
        .ref_vld(ref_vld), .ext_vld(ext_vld),
        .ref_take(ref_take), .ext_take(ext_take)
    );

    // assemble the status word
    always_comb begin
        status             = '0;
        status[SB_REF_VLD] = ref_vld;
        status[SB_EXT_VLD] = ext_vld;
        status[SB_PRE_ACK] = preset_ack;
        status[SB_UNDER]   = unf;
        status[SB_OVER]    = ovf;
        status[SB_EXT_LVL] = ext_lvl;
    end
endmodule

// File: rtl/ecc_checker.sv
// ecc_checker: temporal properties of enc_capture_ctrl, attached by bind.
module ecc_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             cnt_dir,
    input logic [CNT_W-1:0] preset_val,
    input logic [7:0]       ctrl,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] latch_val,
    input logic [7:0]       status,
    input logic             preset_load,
    input logic             ref_take,
    input logic             ext_take,
    input logic             ref_lvl
);
    assert_wrap_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset_load && cnt_en && cnt_dir && count == {CNT_W{1'b1}}) |=> status[4]);

    assert_wrap_dn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset_load && cnt_en && !cnt_dir && count == '0) |=> status[3]);

    assert_preset_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        preset_load |=> (count == $past(preset_val)) && !status[4] && !status[3]);

    assert_ack_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[2] |=> !status[2]);

    assert_latch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_take && !ext_take) |=> $stable(latch_val));

    assert_ref_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ref_take |=> (latch_val == $past(count)) && status[0]);

    assert_ref_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ref_take |=> !$rose(status[1]));

    assert_ref_vld_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && ref_lvl) |=> status[0]);

    assert_ext_release_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[1] && !ctrl[3]) |=> !status[1]);
endmodule

bind enc_capture_ctrl ecc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_dir(cnt_dir),
    .preset_val(preset_val), .ctrl(ctrl), .count(count),
    .latch_val(latch_val), .status(status), .preset_load(preset_load),
    .ref_take(ref_take), .ext_take(ext_take), .ref_lvl(ref_lvl)
);

// File: tb/enc_capture_ctrl_tb.sv
// Directed bench for enc_capture_ctrl: one task per scenario.
module enc_capture_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cnt_en, cnt_dir, ref_in, ext_in;
    logic [31:0] preset_val;
    logic [7:0]  ctrl;
    logic [31:0] count, latch_val;
    logic [7:0]  status;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    enc_capture_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_dir(cnt_dir),
        .ref_in(ref_in), .ext_in(ext_in), .preset_val(preset_val),
        .ctrl(ctrl), .count(count), .latch_val(latch_val), .status(status)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_preset(input logic [31:0] v);
        preset_val = v;
        ctrl[2] = 1'b1;
        step(1);
        ctrl[2] = 1'b0;
        step(1);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; cnt_en = 0; cnt_dir = 0; ref_in = 0; ext_in = 0;
        preset_val = '0; ctrl = '0;
        step(3);
        rst_n = 1'b1;
        check("R1 count", count, 0);
        check("R1 latch", latch_val, 0);
        check("R1 status", {24'd0, status}, 0);
    endtask

    task automatic t_count;
        cnt_en = 1; cnt_dir = 1; step(5);
        check("R2 up", count, 5);
        cnt_dir = 0; step(2);
        check("R2 down", count, 3);
        cnt_en = 0; step(3);
        check("R2 hold", count, 3);
    endtask

    task automatic t_preset;
        preset_val = 32'd100; ctrl[2] = 1; step(1);
        check("R5 load", count, 100);
        check("R6 ack not yet", {31'd0, status[2]}, 0);
        step(1);
        check("R6 ack high", {31'd0, status[2]}, 1);
        cnt_en = 1; cnt_dir = 1; step(3);
        cnt_en = 0;
        check("R5 no reload while held", count, 103);
        ctrl[2] = 0; step(1);
        check("R6 ack low", {31'd0, status[2]}, 0);
    endtask

    task automatic t_overflow;
        preset_val = 32'hFFFF_FFFE; ctrl[2] = 1; step(1);
        ctrl[2] = 0; cnt_en = 1; cnt_dir = 1; step(1);
        check("R3 before wrap", {31'd0, status[4]}, 0);
        step(1);
        cnt_en = 0;
        check("R3 wrapped count", count, 0);
        check("R3 overflow set", {31'd0, status[4]}, 1);
        step(2);
        check("R3 overflow sticky", {31'd0, status[4]}, 1);
        do_preset(32'd5);
        check("R5 preset clears overflow", {31'd0, status[4]}, 0);
    endtask

    task automatic t_underflow;
        do_preset(32'd1);
        cnt_en = 1; cnt_dir = 0; step(2);
        cnt_en = 0;
        check("R4 wrapped count", count, 32'hFFFF_FFFF);
        check("R4 underflow set", {31'd0, status[3]}, 1);
        check("R4 no overflow", {31'd0, status[4]}, 0);
        do_preset(32'd0);
        check("R5 preset clears underflow", {31'd0, status[3]}, 0);
    endtask

    task automatic t_ext;
        do_preset(32'h1234);
        ctrl[1] = 1; step(1);
        ext_in = 1; step(4);
        check("R7 rise capture", latch_val, 32'h1234);
        check("R7 ext valid", {31'd0, status[1]}, 1);
        check("R14 ext level high", {31'd0, status[5]}, 1);
        do_preset(32'h5555);
        ext_in = 0; step(4);
        ext_in = 1; step(4);
        check("R9 latch held", latch_val, 32'h1234);
        ctrl[1] = 0; step(1);
        check("R13 ext valid released", {31'd0, status[1]}, 0);
        ctrl[3] = 1; step(1);
        ext_in = 0; step(4);
        check("R8 fall capture", latch_val, 32'h5555);
        check("R13 re-armed valid", {31'd0, status[1]}, 1);
        check("R14 ext level low", {31'd0, status[5]}, 0);
        check("R14 upper bits", {30'd0, status[7:6]}, 0);
        ctrl[3] = 0; step(1);
    endtask

    task automatic t_ref;
        do_preset(32'h0A0A);
        ctrl[0] = 1; step(1);
        ref_in = 1; step(4);
        check("R10 ref capture", latch_val, 32'h0A0A);
        check("R10 ref valid", {31'd0, status[0]}, 1);
        ctrl[0] = 0; step(2);
        check("R12 held while ref high", {31'd0, status[0]}, 1);
        ref_in = 0; step(4);
        check("R12 released", {31'd0, status[0]}, 0);
    endtask

    task automatic t_contest;
        do_preset(32'h7777);
        ctrl[0] = 1; ctrl[1] = 1; step(1);
        ref_in = 1; ext_in = 1; step(4);
        check("R11 latch from ref", latch_val, 32'h7777);
        check("R11 ref valid", {31'd0, status[0]}, 1);
        check("R11 ext valid low", {31'd0, status[1]}, 0);
        ctrl = '0; ref_in = 0; ext_in = 0; step(4);
    endtask

    initial begin
        step(1);
        t_reset();
        t_count();
        t_preset();
        t_overflow();
        t_underflow();
        t_ext();
        t_ref();
        t_contest();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule